// File: doc/BRIEF.md
# Sequence Step Detector with Post-Match Delay

This block decides when one step of a supply power-up or power-down sequence has finished. It watches a vector of monitored flags: supply-good comparator outputs, general logic inputs and warning flags. A per-step configuration chooses one flag, says whether that flag should be inverted, and gives a delay. When a step begins, the controller pulses `step_load`, and the block takes a copy of the configuration at that moment. It then waits for the chosen condition to be true and counts the delay while the condition stays true. When the delay has run out it raises `step_done` for one cycle.

An unconditional-jump bit forces the condition true, so the step becomes a pure delay. The delay is counted in prescaled ticks of `TICK_DIV` clock cycles each. With the defaults (100 MHz clock, `TICK_DIV` = 1000, 16-bit delay) one tick is 10 µs, so any delay from 10 µs up to and beyond 400 ms can be set with the same counter.

The block has no data stream. Every pin is a plain level or pulse, and it has no handshake and no back-pressure.

Top module: `seq_step_detect`

## Requirements
- R1: After reset, and until the first `step_load`, `step_done` stays low whatever the inputs do.
- R2: The step condition depends only on the one input `mon_in[cfg_sel]` named by the latched select index. Changes on every other input have no effect.
- R3: When the latched invert bit is 1, the condition is true while the selected input is 0. When the bit is 0, the condition is true while the input is 1.
- R4: When the latched jump bit is 1, the condition counts as true whatever the inputs are. Only the delay then gates `step_done`.
- R5: Let D be the latched delay. If the condition is sampled true on D·TICK_DIV+1 consecutive rising edges after a load, `step_done` is high in the cycle that follows the last of those edges.
- R6: If the condition is sampled false before the delay has run out, the count starts over from zero.
- R7: The configuration inputs are captured only on a `step_load` edge and are ignored at all other times. A load clears any count in progress. The condition is not evaluated on the load edge itself.
- R8: With a latched delay of 0, `step_done` is high in the cycle after the first edge at which the condition is sampled true.
- R9: `step_done` is a single-cycle pulse. It is not issued again until the next `step_load`, even if the condition stays true.
- R10: A select index of `N_IN` or more makes the condition false (unless jump is set), whatever the invert bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_load | input | 1 | Step-entry pulse: latches the configuration and restarts the detector |
| cfg_sel | input | SEL_W | Index of the monitored input to test |
| cfg_invert | input | 1 | Invert the selected input before testing |
| cfg_jump | input | 1 | Treat the condition as always true |
| cfg_delay | input | DLY_W | Post-match delay in prescaled ticks |
| mon_in | input | N_IN | Monitored flags (supply, logic, warning) |
| step_done | output | 1 | One-cycle pulse when the step is complete |

## Verification
The hardest case to reach from the ports is a condition that drops out partway through a long delay and then holds true to the end. The stimulus must hold the selected bit steady for many tick periods, drop it for a single cycle, and keep it steady again for the full window. Randomly toggled flags almost never do this. The bench therefore holds the monitored vector steady and flips a random bit only rarely, so the unselected bits still change often while the selected bit gets long stable stretches. Directed runs add the one-cycle dropout, a load that arrives while a count is in progress, and select indices beyond the input width.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_ARMED = 1'b1
  } ssd_phase_e;
endpackage

// File: rtl/ssd_cond_select.sv
module ssd_cond_select #(
  parameter int N_IN  = 16,
  parameter int SEL_W = 4
) (
  input  logic [N_IN-1:0]  mon_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  input  logic             jump,
  output logic             cond
);
  localparam logic [SEL_W:0] N_LIM = (SEL_W+1)'(N_IN);

  logic [N_IN-1:0] hit;
  logic            picked;
  logic            in_range;

  // one-hot style AND-OR mux over the monitored vector
  for (genvar g = 0; g < N_IN; g++) begin : g_hit
    assign hit[g] = (sel == SEL_W'(g)) && mon_in[g];
  end

  assign picked   = |hit;
  assign in_range = ({1'b0, sel} < N_LIM);
  assign cond     = jump | (in_range & (picked ^ invert));

  // R4: forced condition
  always_comb begin
    if (jump === 1'b1) a_r4_jump_forces: assert (cond === 1'b1);
  end
endmodule

// File: rtl/ssd_prescale.sv
module ssd_prescale #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R5: the prescaler never passes its terminal count
  a_r5_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: a stall returns the prescaler to zero
  a_r6_prescale_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/ssd_delay_timer.sv
module ssd_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             armed,
  input  logic             cond,
  input  logic             tick,
  input  logic [DLY_W-1:0] delay,
  output logic             expire
);
  logic [DLY_W-1:0] tick_cnt;
  logic             active;

  assign active = armed && cond && !load;
  assign expire = active && (tick_cnt == delay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tick_cnt <= '0;
    else if (load || !active)  tick_cnt <= '0;
    else if (expire)           tick_cnt <= tick_cnt;
    else if (tick)             tick_cnt <= tick_cnt + 1'b1;
  end

  // R5: the count never passes the programmed delay while armed
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load) |-> tick_cnt <= delay);
  // R6: a false condition restarts the count
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cond && !load) |=> tick_cnt == '0);
  // R7: a load clears the count
  a_r7_load_clears_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tick_cnt == '0);
endmodule

// File: rtl/seq_step_detect.sv
module seq_step_detect
  import ssd_pkg::*;
#(
  parameter int N_IN     = 16,
  parameter int DLY_W    = 16,
  parameter int TICK_DIV = 1000,
  localparam int SEL_W   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_load,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_invert,
  input  logic             cfg_jump,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [N_IN-1:0]  mon_in,
  output logic             step_done
);
  logic [SEL_W-1:0] sel_q;
  logic             inv_q;
  logic             jump_q;
  logic [DLY_W-1:0] delay_q;
  ssd_phase_e       phase;
  logic             armed;
  logic             cond;
  logic             tick;
  logic             expire;
  logic             pre_run;

  // configuration is captured only at step entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      inv_q   <= 1'b0;
      jump_q  <= 1'b0;
      delay_q <= '0;
    end else if (step_load) begin
      sel_q   <= cfg_sel;
      inv_q   <= cfg_invert;
      jump_q  <= cfg_jump;
      delay_q <= cfg_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= PH_IDLE;
    else if (step_load)  phase <= PH_ARMED;
    else if (expire)     phase <= PH_IDLE;
  end

  assign armed = (phase == PH_ARMED);

  ssd_cond_select #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
    .mon_in (mon_in),
    .sel    (sel_q),
    .invert (inv_q),
    .jump   (jump_q),
    .cond   (cond)
  );

  assign pre_run = armed && cond && !step_load && !expire;

  ssd_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pre_run),
    .tick  (tick)
  );

  ssd_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (step_load),
    .armed  (armed),
    .cond   (cond),
    .tick   (tick),
    .delay  (delay_q),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_done <= 1'b0;
    else        step_done <= expire;
  end

  // R9: single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);
  // R9: no reissue until next load
  a_r9_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !$past(step_load)) |-> phase == PH_IDLE);
  // R7: load arms and suppresses done
  a_r7_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    step_load |=> (phase == PH_ARMED) && !step_done);
  // R8: zero delay fires on the next cycle
  a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cond && !step_load && delay_q == '0) |=> step_done);
  // R1: nothing fires while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !step_load) |=> !step_done);
endmodule

// File: tb/seq_step_detect_tb.sv
module seq_step_detect_tb;
  localparam int TN   = 12;
  localparam int TDW  = 6;
  localparam int TDIV = 3;
  localparam int TSW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           step_load = 1'b0;
  logic [TSW-1:0] cfg_sel = '0;
  logic           cfg_invert = 1'b0;
  logic           cfg_jump = 1'b0;
  logic [TDW-1:0] cfg_delay = '0;
  logic [TN-1:0]  mon_in = '0;
  logic           step_done;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // bench reference state
  bit             m_armed = 0;
  logic [TSW-1:0] m_sel = '0;
  bit             m_inv = 0;
  bit             m_jump = 0;
  int             m_dly = 0;
  int             m_run = 0;
  bit             exp_done = 0;

  always #5 clk = ~clk;

  seq_step_detect #(.N_IN(TN), .DLY_W(TDW), .TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_load(step_load), .cfg_sel(cfg_sel),
    .cfg_invert(cfg_invert), .cfg_jump(cfg_jump), .cfg_delay(cfg_delay),
    .mon_in(mon_in), .step_done(step_done));

  function automatic bit cond_of(logic [TN-1:0] m, logic [TSW-1:0] s, bit i, bit j);
    if (j) return 1'b1;
    if (int'(s) >= TN) return 1'b0;
    return m[s] ^ i;
  endfunction

  task automatic check_done();
    total++;
    if (step_done !== exp_done) begin
      bad++;
      $display("FAIL %s: step_done=%0b expected=%0b at %0t", cur_req, step_done, exp_done, $time);
    end
  endtask

  // one cycle: drive at negedge, predict the edge, compare after it
  task automatic cyc(input logic [TN-1:0] m, input bit ld);
    mon_in    = m;
    step_load = ld;
    exp_done  = 0;
    if (ld) begin
      m_sel = cfg_sel; m_inv = cfg_invert; m_jump = cfg_jump;
      m_dly = int'(cfg_delay); m_armed = 1; m_run = 0;
    end else if (m_armed) begin
      if (cond_of(m, m_sel, m_inv, m_jump)) begin
        if (m_run == m_dly * TDIV) begin exp_done = 1; m_armed = 0; end
        else m_run++;
      end else m_run = 0;
    end
    @(posedge clk);
    @(negedge clk);
    step_load = 1'b0;
    check_done();
  endtask

  task automatic set_cfg(input int s, input bit i, input bit j, input int d);
    cfg_sel = TSW'(s); cfg_invert = i; cfg_jump = j; cfg_delay = TDW'(d);
  endtask

  task automatic hold(input logic [TN-1:0] m, input int n);
    for (int k = 0; k < n; k++) cyc(m, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [TN-1:0] m;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset state and quiet before any load
    cur_req = "R1";
    for (int k = 0; k < 3; k++) begin @(negedge clk); total++; if (step_done !== 1'b0) begin bad++; $display("FAIL R1: step_done=%0b expected=0", step_done); end end
    rst_n = 1'b1;
    hold('1, 6);

    // R2 / R8: zero delay, selected bit only
    cur_req = "R2"; set_cfg(5, 0, 0, 0); cyc('0, 1);
    hold(~(TN'(1) << 5), 4);
    cur_req = "R8"; cyc(TN'(1) << 5, 0);
    cur_req = "R9"; hold(TN'(1) << 5, 5);

    // R3: inverted, waits for a low level
    cur_req = "R3"; set_cfg(2, 1, 0, 2); cyc('1, 1);
    hold('1, 4);
    hold(~(TN'(1) << 2), 10);

    // R6: single-cycle dropout restarts the count
    cur_req = "R6"; set_cfg(7, 0, 0, 3); cyc('0, 1);
    hold(TN'(1) << 7, 6);
    hold('0, 1);
    hold(TN'(1) << 7, 14);

    // R4: jump, pure delay
    cur_req = "R4"; set_cfg(9, 1, 1, 2); cyc('1, 1);
    hold('1, 3); hold('0, 8);

    // R7: config changes without load are ignored; load mid-count restarts
    cur_req = "R7"; set_cfg(1, 0, 0, 4); cyc('0, 1);
    hold(TN'(2), 5);
    set_cfg(3, 0, 0, 0);
    hold(TN'(2), 4);
    cyc(TN'(2), 1);
    hold(TN'(2), 3);
    hold(TN'(8), 3);

    // R10: out-of-range index never matches, either polarity
    cur_req = "R10"; set_cfg(13, 0, 0, 0); cyc('1, 1); hold('1, 6);
    set_cfg(14, 1, 0, 0); cyc('0, 1); hold('0, 6);

    // R5: constrained random steps
    cur_req = "R5";
    for (int it = 0; it < 60; it++) begin
      set_cfg(int'($urandom_range(0, 13)), bit'($urandom_range(0, 1)),
              ($urandom_range(0, 7) == 0), int'($urandom_range(0, 5)));
      m = TN'($urandom);
      cyc(m, 1);
      for (int k = 0; k < int'($urandom_range(15, 35)); k++) begin
        if ($urandom_range(0, 5) == 0) m[$urandom_range(0, TN-1)] ^= 1'b1;
        cyc(m, 0);
      end
    end

    summary();
    $finish;
  end
endmodule